// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates an input address by walking a multi-level radix tree stored in memory. A request supplies the address to translate, the base of the root directory, the index width of the root directory and a root-size field that sets the total number of address bits the tree covers. The walker then reads one 8-byte entry per level through a valid/ready read port and follows directory entries until it finds a leaf.

Each directory entry sets the index width of the level below it. The page size is not fixed: it is the number of address bits still unused when the walk reaches a leaf. A finished walk gives a one-cycle result. That result carries the real address, the leaf entry, the memory address the leaf was read from (so that a later referenced/changed update can write back to it) and the page size. If the walk fails, the result carries a fault code instead.

Top module: `radix_walker`

## Requirements
- R1: If the index width of any level is below 5, the walk ends with fault code 1 (bad configuration) and no read is issued for that level.
- R2: If the index width of a level is larger than the number of address bits still remaining, the walk ends with fault code 1 and no read is issued for that level.
- R3: The address read at each level is the directory base plus 8 times the index. The index is the input address shifted right by (remaining bits minus index width), keeping the low index-width bits. Read addresses are always 8-byte aligned.
- R4: An entry whose bit 63 (valid) is 0 ends the walk with fault code 2 (no entry). The reported entry address is the address of that entry.
- R5: A valid entry whose bit 62 (leaf) is 0 is a directory. Its bits 55:8, with zeros below, form the next directory base, and its bits 4:0 give the next index width. The remaining bit count drops by the current index width at every level.
- R6: At a valid leaf, fault code is 0. The page size is the remaining bit count after this level's subtraction. The real address is the leaf's bits 55:12 above the page size ORed with the input address bits below it. The leaf entry and its read address are reported.
- R7: The remaining bit count starts at 31 plus the root-size field. A walk that still needs a fifth read after four directory levels ends with fault code 1 after exactly four reads.
- R8: req_ready is high only while idle. rd_valid and rd_addr stay unchanged until rd_ready is seen. done_valid is high for exactly one cycle per accepted request.
- R9: After reset the walker is idle: req_ready is 1, and rd_valid and done_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and takes the request |
| req_addr | input | 64 | Address to translate |
| req_root_base | input | 64 | Root directory base (bits 55:8 used) |
| req_root_nls | input | 5 | Index width of the root directory |
| req_root_size | input | 5 | Root-size field; 31 is added to it |
| rd_valid | output | 1 | Entry read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 64 | Byte address of the entry |
| rsp_valid | input | 1 | Read data present |
| rsp_data | input | 64 | Fetched entry |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 2 | 0 none, 1 bad configuration, 2 no entry |
| done_raddr | output | 64 | Translated real address |
| done_pte | output | 64 | Last fetched entry |
| done_pte_addr | output | 64 | Address of the last fetched entry |
| done_psize | output | 7 | Page size in address bits |

## Verification
Some properties are checked on every cycle. The read request must stay stable until it is accepted. The result strobe must last exactly one cycle. Read addresses must be aligned. The idle state must exclude reads and results. A clean result must carry a valid leaf, and a no-entry fault must carry an invalid entry. The bench's scenarios are what show the index arithmetic, the base and width taken from each directory entry, the page size, the real address, the read counts on each fault path and the level limit. They do this against a software walk of the same memory contents.

// File: rtl/radix_walker_pkg.sv
package radix_walker_pkg;
    localparam int ADDR_W  = 64;
    localparam int ENTRY_W = 64;
    localparam int NLS_W   = 5;
    localparam int SIZE_W  = 7;
    localparam int VALID_BIT = 63;
    localparam int LEAF_BIT  = 62;
    localparam logic [ADDR_W-1:0] DIR_BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
    localparam logic [ADDR_W-1:0] PAGE_NUM_MASK = 64'h00FF_FFFF_FFFF_F000;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_BADCFG = 2'd1,
        FLT_NOPTE  = 2'd2
    } walk_fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/walk_index.sv
module walk_index
    import radix_walker_pkg::*;
#(
    parameter int MAX_LEVELS = 4,
    parameter int MIN_NLS    = 5,
    localparam int LVL_W     = $clog2(MAX_LEVELS + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [NLS_W-1:0]  nls,
    input  logic [SIZE_W-1:0] rem,
    input  logic [LVL_W-1:0]  lvl,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              cfg_bad
);
    logic [SIZE_W-1:0] shift;
    logic [ADDR_W-1:0] idx_mask;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        shift      = rem - SIZE_W'(nls);
        idx_mask   = (ADDR_W'(1) << nls) - ADDR_W'(1);
        idx        = (addr >> shift) & idx_mask;
        entry_addr = base + (idx << 3);
        cfg_bad    = (nls < NLS_W'(MIN_NLS))
                   || (SIZE_W'(nls) > rem)
                   || (lvl >= LVL_W'(MAX_LEVELS));
    end
endmodule

// File: rtl/leaf_compose.sv
module leaf_compose
    import radix_walker_pkg::*;
(
    input  logic [ENTRY_W-1:0] pte,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SIZE_W-1:0]  psize,
    output logic [ADDR_W-1:0]  raddr
);
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        low_mask = (ADDR_W'(1) << psize) - ADDR_W'(1);
        raddr    = ((pte & PAGE_NUM_MASK) & ~low_mask) | (addr & low_mask);
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walker_pkg::*;
#(
    parameter int MAX_LEVELS = 4,
    parameter int MIN_NLS    = 5,
    parameter int SIZE_BIAS  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    input  logic [63:0]       req_root_base,
    input  logic [4:0]        req_root_nls,
    input  logic [4:0]        req_root_size,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [63:0]       rd_addr,
    input  logic              rsp_valid,
    input  logic [63:0]       rsp_data,
    output logic              done_valid,
    output logic [1:0]        done_fault,
    output logic [63:0]       done_raddr,
    output logic [63:0]       done_pte,
    output logic [63:0]       done_pte_addr,
    output logic [6:0]        done_psize
);
    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    typedef struct packed {
        walk_state_e         st;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   base;
        logic [NLS_W-1:0]    nls;
        logic [SIZE_W-1:0]   rem;
        logic [LVL_W-1:0]    lvl;
        logic [ENTRY_W-1:0]  pte;
        logic [ADDR_W-1:0]   pte_addr;
        logic [ADDR_W-1:0]   raddr;
        logic [SIZE_W-1:0]   psize;
        walk_fault_e         fault;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [ADDR_W-1:0] entry_addr;
    logic              cfg_bad;
    logic [SIZE_W-1:0] leaf_size;
    logic [ADDR_W-1:0] leaf_raddr;

    walk_index #(
        .MAX_LEVELS (MAX_LEVELS),
        .MIN_NLS    (MIN_NLS)
    ) u_index (
        .addr       (r_q.addr),
        .base       (r_q.base),
        .nls        (r_q.nls),
        .rem        (r_q.rem),
        .lvl        (r_q.lvl),
        .entry_addr (entry_addr),
        .cfg_bad    (cfg_bad)
    );

    assign leaf_size = r_q.rem - SIZE_W'(r_q.nls);

    leaf_compose u_leaf (
        .pte   (rsp_data),
        .addr  (r_q.addr),
        .psize (leaf_size),
        .raddr (leaf_raddr)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st       = ST_ISSUE;
                    r_d.addr     = req_addr;
                    r_d.base     = req_root_base & DIR_BASE_MASK;
                    r_d.nls      = req_root_nls;
                    r_d.rem      = SIZE_W'(SIZE_BIAS) + SIZE_W'(req_root_size);
                    r_d.lvl      = '0;
                    r_d.pte      = '0;
                    r_d.pte_addr = '0;
                    r_d.raddr    = '0;
                    r_d.psize    = '0;
                    r_d.fault    = FLT_NONE;
                end
            end
            ST_ISSUE: begin
                if (cfg_bad) begin
                    r_d.fault = FLT_BADCFG;
                    r_d.st    = ST_DONE;
                end else if (rd_ready) begin
                    r_d.pte_addr = entry_addr;
                    r_d.st       = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    r_d.pte = rsp_data;
                    if (!rsp_data[VALID_BIT]) begin
                        r_d.fault = FLT_NOPTE;
                        r_d.st    = ST_DONE;
                    end else begin
                        r_d.rem = leaf_size;
                        r_d.lvl = r_q.lvl + LVL_W'(1);
                        if (rsp_data[LEAF_BIT]) begin
                            r_d.psize = leaf_size;
                            r_d.raddr = leaf_raddr;
                            r_d.fault = FLT_NONE;
                            r_d.st    = ST_DONE;
                        end else begin
                            r_d.base = rsp_data & DIR_BASE_MASK;
                            r_d.nls  = rsp_data[NLS_W-1:0];
                            r_d.st   = ST_ISSUE;
                        end
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, fault: FLT_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign rd_valid      = (r_q.st == ST_ISSUE) && !cfg_bad;
    assign rd_addr       = entry_addr;
    assign done_valid    = (r_q.st == ST_DONE);
    assign done_fault    = r_q.fault;
    assign done_raddr    = r_q.raddr;
    assign done_pte      = r_q.pte;
    assign done_pte_addr = r_q.pte_addr;
    assign done_psize    = r_q.psize;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [63:0] rd_addr,
    input logic        done_valid,
    input logic [1:0]  done_fault,
    input logic [63:0] done_pte
);
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R3
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_addr[2:0] == 3'b000));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rd_valid && !done_valid));

    // R6
    leaf_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 2'd0) |-> (done_pte[63] && done_pte[62]));

    // R4
    nopte_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 2'd2) |-> !done_pte[63]);
endmodule

bind radix_walker radix_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .done_valid (done_valid),
    .done_fault (done_fault),
    .done_pte   (done_pte)
);

// File: tb/tb_radix_walker.sv
`timescale 1ns/1ps
module tb_radix_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [63:0] req_root_base = '0;
    logic [4:0]  req_root_nls = '0;
    logic [4:0]  req_root_size = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [63:0] rd_addr;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        done_valid;
    logic [1:0]  done_fault;
    logic [63:0] done_raddr, done_pte, done_pte_addr;
    logic [6:0]  done_psize;

    always #4 clk = ~clk;

    radix_walker dut (.*);

    logic [63:0] mem [logic [63:0]];
    int nls_arr [8];
    int n_checks = 0;
    int n_fail = 0;
    int n_reads = 0;

    function automatic logic [63:0] mem_rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model with random accept and response delays
    initial begin
        bit pend = 0;
        int dly = 0;
        logic [63:0] pa = '0;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = mem_rd(pa);
                    pend = 0;
                end else dly--;
            end
            rd_ready = 1'b0;
            if (!pend && !rsp_valid && rd_valid && ($urandom % 3 != 0)) begin
                rd_ready = 1'b1;
                pend = 1;
                dly = $urandom % 3;
                pa = rd_addr;
                n_reads++;
            end
        end
    end

    // software walk from the requirements
    task automatic model(input logic [63:0] a, input logic [63:0] b, input int rs,
                         output int flt, output logic [63:0] ra, output logic [63:0] pte,
                         output logic [63:0] paddr, output int psz, output int nrd);
        int rem = 31 + rs;
        int nl = nls_arr[0];
        logic [63:0] base = b & 64'h00FF_FFFF_FFFF_FF00;
        logic [63:0] idx, e, m;
        nrd = 0; ra = 0; pte = 0; paddr = 0; psz = 0; flt = 0;
        for (int l = 0; l < 16; l++) begin
            if (l == 4 || nl < 5 || nl > rem) begin flt = 1; return; end
            idx = (a >> (rem - nl)) & ((64'd1 << nl) - 1);
            paddr = base + (idx << 3);
            e = mem_rd(paddr);
            pte = e;
            nrd++;
            if (!e[63]) begin flt = 2; return; end
            rem -= nl;
            if (e[62]) begin
                psz = rem;
                m = (64'd1 << rem) - 1;
                ra = ((e & 64'h00FF_FFFF_FFFF_F000) & ~m) | (a & m);
                return;
            end
            base = e & 64'h00FF_FFFF_FFFF_FF00;
            nl = int'(e[4:0]);
        end
    endtask

    task automatic build(input logic [63:0] a, input logic [63:0] b, input int rs,
                         input int nlev, input bit last_leaf, input int bad_lvl);
        int rem = 31 + rs;
        logic [63:0] base = b & 64'h00FF_FFFF_FFFF_FF00;
        logic [63:0] idx, ea, e, nb;
        for (int l = 0; l < nlev; l++) begin
            int nl = nls_arr[l];
            if (nl > rem || nl < 5) break;
            idx = (a >> (rem - nl)) & ((64'd1 << nl) - 1);
            ea = base + (idx << 3);
            rem -= nl;
            nb = {$urandom, $urandom} & 64'h00FF_FFFF_FFFF_FF00;
            if (l == nlev - 1 && last_leaf) begin
                e = {$urandom, $urandom};
                e[63] = 1'b1;
                e[62] = 1'b1;
            end else begin
                e = '0;
                e[63] = 1'b1;
                e[55:8] = nb[55:8];
                e[4:0] = 5'(nls_arr[l + 1]);
            end
            if (l == bad_lvl) e[63] = 1'b0;
            mem[ea] = e;
            base = nb;
        end
    endtask

    task automatic run(input logic [63:0] a, input logic [63:0] b, input int rs, input string tag);
        int eflt, epsz, enrd, wd;
        logic [63:0] era, epte, epa;
        model(a, b, rs, eflt, era, epte, epa, epsz, enrd);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_root_base = b;
        req_root_nls = 5'(nls_arr[0]);
        req_root_size = 5'(rs);
        n_reads = 0;
        @(negedge clk);
        req_valid = 1'b0;
        // R8: busy once a request is taken
        chk(req_ready == 1'b0, {"R8 busy ", tag}, 64'(req_ready), 64'd0);
        wd = 0;
        while (!done_valid && wd < 300) begin
            @(negedge clk);
            wd++;
        end
        chk(done_valid == 1'b1, {"R8 done ", tag}, 64'(done_valid), 64'd1);
        if (!done_valid) return;
        chk(done_fault == 2'(eflt), {tag, " fault"}, 64'(done_fault), 64'(eflt));
        chk(n_reads == enrd, {tag, " reads"}, 64'(n_reads), 64'(enrd));
        if (eflt == 0) begin
            chk(done_raddr == era, "R6 raddr", done_raddr, era);
            chk(done_psize == 7'(epsz), "R6 psize", 64'(done_psize), 64'(epsz));
            chk(done_pte == epte, "R6 pte", done_pte, epte);
            chk(done_pte_addr == epa, "R3 pte_addr", done_pte_addr, epa);
        end else if (eflt == 2) begin
            chk(done_pte_addr == epa, "R4 pte_addr", done_pte_addr, epa);
        end
        @(negedge clk);
        // R8: single-cycle result
        chk(done_valid == 1'b0, {"R8 pulse ", tag}, 64'(done_valid), 64'd0);
    endtask

    initial begin
        int t;
        t = 0;
        forever begin
            @(posedge clk);
            t++;
            if (t > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(req_ready == 1'b1, "R9 req_ready", 64'(req_ready), 64'd1);
        chk(rd_valid == 1'b0, "R9 rd_valid", 64'(rd_valid), 64'd0);
        chk(done_valid == 1'b0, "R9 done_valid", 64'(done_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: root width below minimum, no reads
        mem.delete();
        a = {$urandom, $urandom};
        b = 64'h0000_1000_0000_0000;
        nls_arr[0] = 4;
        run(a, b, 0, "R1 root");
        // R1: second level width below minimum
        mem.delete();
        nls_arr[0] = 10; nls_arr[1] = 3;
        build(a, b, 0, 1, 0, -1);
        run(a, b, 0, "R1 level2");
        // R2: width larger than remaining bits
        mem.delete();
        nls_arr[0] = 20; nls_arr[1] = 13;
        build(a, b, 0, 1, 0, -1);
        run(a, b, 0, "R2 overrun");
        // R4: invalid entry at second level
        mem.delete();
        nls_arr[0] = 9; nls_arr[1] = 9; nls_arr[2] = 9;
        build(a, b, 3, 3, 1, 1);
        run(a, b, 3, "R4 invalid");
        // R7: level limit with 5-bit widths over 62 bits
        mem.delete();
        for (int i = 0; i < 5; i++) nls_arr[i] = 5;
        build(a, b, 31, 4, 0, -1);
        run(a, b, 31, "R7 limit");
        // R6: single-level leaf using the whole width, page size 0
        mem.delete();
        nls_arr[0] = 31;
        build(a, b, 0, 1, 1, -1);
        run(a, b, 0, "R6 flat");

        // random trees: R3 R5 R6 R4
        for (int n = 0; n < 300; n++) begin
            int rs, nlev, rem, bad;
            mem.delete();
            rs = $urandom_range(0, 31);
            rem = 31 + rs;
            nlev = $urandom_range(1, 4);
            for (int l = 0; l < nlev; l++) begin
                int mx = rem - 5 * (nlev - 1 - l);
                if (mx > 13) mx = 13;
                nls_arr[l] = $urandom_range(5, mx);
                rem -= nls_arr[l];
            end
            bad = ($urandom % 8 == 0) ? $urandom_range(0, nlev - 1) : -1;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            build(a, b, rs, nlev, 1, bad);
            run(a, b, rs, "R5 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule